// File: doc/BRIEF.md
# Serial Command Port Front End with Resynchronization and Soft Reset

This block sits at the entry of a byte-wide serial command port on a converter-style peripheral. It works in the system clock domain. The serial clock, data and active-low select inputs are treated as synchronous samples. A rising edge of the serial clock is found by comparing the current sample with the previous one. While select is low, bits are taken most significant first. Each finished byte goes to a command decoder over a valid/ready interface.

A serial link has no reset pin, so it can lose track of where bytes start. To recover, the host sends a long run of all-ones bytes followed by one byte ending in a zero. When the block sees that pattern, it emits a one-cycle pulse that tells the decoder to expect a fresh command byte. Only the framing state is affected; no register content changes.

The block also holds the 32-bit configuration register. Setting its reset bit (bit 29) starts a software reset. The reset drives a reset request for a fixed number of cycles, loads the register's default value, and then raises a reset-done flag (bit 28). A read of the register clears that flag.

The decoder interface has this back-pressure rule. The serial side cannot be stalled. A byte stays presented with stable data until `cmd_ready` accepts it. If the next byte arrives before then, it replaces the pending byte.

Top module: `serial_cmd_front`

## Requirements
- R1: While `cs_n` is low, on every rising edge of `sclk` one `sdin` bit is taken, most significant bit first. After eight bits the byte appears on `cmd_data` with `cmd_valid` high.
- R2: `cmd_valid` stays high with `cmd_data` unchanged until a cycle with `cmd_ready` high, after which it drops. A new byte that completes while one is pending overwrites it.
- R3: While `cs_n` is high no bits are taken, and any partly received byte is dropped. The next byte starts fresh after `cs_n` goes low again.
- R4: At least 15 consecutive 0xFF bytes followed by a 0xFE byte give a one-cycle `resync_pulse`. The terminating 0xFE is not presented to the decoder, and any pending byte is withdrawn.
- R5: The 0xFF run count saturates at 15, so longer runs still qualify. Any byte other than 0xFF restarts the count, and a 0xFE after fewer than 15 0xFF bytes is an ordinary byte.
- R6: Raising `cs_n` between bytes does not clear the 0xFF run count.
- R7: A resynchronization leaves `cfg_q` unchanged.
- R8: A write with bit 29 set loads the default configuration and ignores every other field of that write. It then holds `soft_rst_req` high for exactly 8 cycles.
- R9: When `soft_rst_req` falls, bit 28 of `cfg_q` reads 1.
- R10: A read (`cfg_rd_en`) clears bit 28 from the next cycle on.
- R11: A write with bit 29 clear loads all fields except bits 28 and 29. Bit 29 always reads 0, bit 28 is not changed by writes, and writes during a software reset are ignored.
- R12: After `rst_n` is released: `cfg_q` equals the default (0), `cmd_valid` is 0, `soft_rst_req` is 0 and `resync_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock sample; bits taken on its rising edge |
| sdin | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low port select |
| cmd_data | output | 8 | Received byte toward the decoder |
| cmd_valid | output | 1 | Byte on `cmd_data` is pending |
| cmd_ready | input | 1 | Decoder accepts the pending byte |
| resync_pulse | output | 1 | One-cycle pulse: port is back to expecting a command byte |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration write value |
| cfg_rd_en | input | 1 | Configuration read strobe (clears the reset-done flag) |
| cfg_q | output | 32 | Configuration register contents |
| soft_rst_req | output | 1 | Software reset in progress; drives the block's register resets |

## Verification
Several properties are checked on every cycle:
- the reset-request window is exactly 8 cycles long and ends with the done flag set;
- bit 29 never reads 1;
- the read clears the done flag;
- a pending byte holds under back-pressure;
- no byte completes while select is high;
- the configuration register is stable when nothing touches it.

Other behaviour depends on byte history and can only be shown by the bench's scenarios:
- the saturation and clearing of the 0xFF run;
- keeping that count across a select toggle;
- dropping a partial byte;
- withdrawing the terminating byte;
- ignoring the other fields on the reset write.

// File: rtl/scf_pkg.sv
package scf_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;
  localparam logic [BYTE_W-1:0] END_BYTE  = 8'hFE;
  // Bit positions of the configuration register that software depends on
  localparam int RST_BIT  = 29;
  localparam int DONE_BIT = 28;
endpackage

// File: rtl/scf_deser.sv
module scf_deser #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         sdin,
  input  logic         cs_n,
  output logic         byte_stb,
  output logic [W-1:0] byte_q
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic          sclk_q;
  logic [CW-1:0] bit_cnt;
  logic [W-1:0]  shreg;
  logic          rise;
  logic [W-1:0]  shnext;

  assign rise   = sclk && !sclk_q;
  assign shnext = {shreg[W-2:0], sdin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_stb <= 1'b0;
      byte_q   <= '0;
    end else begin
      sclk_q   <= sclk;
      byte_stb <= 1'b0;
      if (cs_n) begin
        bit_cnt <= '0;
      end else if (rise) begin
        shreg <= shnext;
        if (bit_cnt == CW'(W-1)) begin
          bit_cnt  <= '0;
          byte_stb <= 1'b1;
          byte_q   <= shnext;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scf_resync.sv
module scf_resync
  import scf_pkg::*;
#(
  parameter int W       = 8,
  parameter int RUN_MIN = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         byte_stb,
  input  logic [W-1:0] byte_in,
  output logic         end_hit,
  output logic         sync_pulse
);
  localparam int RW = $clog2(RUN_MIN + 1);

  logic [RW-1:0] run;
  logic          is_fill;
  logic          run_full;

  assign is_fill  = (byte_in == FILL_BYTE[W-1:0]);
  assign run_full = (run == RW'(RUN_MIN));
  assign end_hit  = byte_stb && run_full && (byte_in == END_BYTE[W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= '0;
      sync_pulse <= 1'b0;
    end else begin
      sync_pulse <= 1'b0;
      if (byte_stb) begin
        if (is_fill) begin
          if (!run_full) run <= run + 1'b1;
        end else begin
          run <= '0;
          if (end_hit) sync_pulse <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scf_cfg.sv
module scf_cfg
  import scf_pkg::*;
#(
  parameter int          CFG_W       = 32,
  parameter int          RST_CYC     = 8,
  parameter logic [31:0] CFG_DEFAULT = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [CFG_W-1:0] cfg_q,
  output logic             busy
);
  localparam int CNT_W = $clog2(RST_CYC + 1);
  localparam logic [CFG_W-1:0] CTRL_MASK =
    (CFG_W'(1) << RST_BIT) | (CFG_W'(1) << DONE_BIT);
  localparam logic [CFG_W-1:0] DEF_CLEAN = CFG_DEFAULT[CFG_W-1:0] & ~CTRL_MASK;

  logic [CNT_W-1:0] cnt;
  logic [CFG_W-1:0] cfg_nxt;

  always_comb begin
    cfg_nxt = cfg_q;
    if (wr_en) cfg_nxt = (wr_data & ~CTRL_MASK) | (cfg_q & (CFG_W'(1) << DONE_BIT));
    if (rd_en) cfg_nxt[DONE_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= DEF_CLEAN;
      busy  <= 1'b0;
      cnt   <= '0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) begin
        busy            <= 1'b0;
        cfg_q[DONE_BIT] <= 1'b1;
      end
    end else if (wr_en && wr_data[RST_BIT]) begin
      busy  <= 1'b1;
      cnt   <= CNT_W'(RST_CYC);
      cfg_q <= DEF_CLEAN;
    end else begin
      cfg_q <= cfg_nxt;
    end
  end
endmodule

// File: rtl/serial_cmd_front.sv
module serial_cmd_front
  import scf_pkg::*;
#(
  parameter int          CFG_W       = 32,
  parameter int          RUN_MIN     = 15,
  parameter int          RST_CYC     = 8,
  parameter logic [31:0] CFG_DEFAULT = 32'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               sdin,
  input  logic               cs_n,
  output logic [BYTE_W-1:0]  cmd_data,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic               resync_pulse,
  input  logic               cfg_wr_en,
  input  logic [CFG_W-1:0]   cfg_wr_data,
  input  logic               cfg_rd_en,
  output logic [CFG_W-1:0]   cfg_q,
  output logic               soft_rst_req
);
  logic              byte_stb;
  logic [BYTE_W-1:0] byte_q;
  logic              end_hit;

  scf_deser #(.W(BYTE_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .cs_n(cs_n),
    .byte_stb(byte_stb), .byte_q(byte_q)
  );

  scf_resync #(.W(BYTE_W), .RUN_MIN(RUN_MIN)) u_resync (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_in(byte_q),
    .end_hit(end_hit), .sync_pulse(resync_pulse)
  );

  scf_cfg #(.CFG_W(CFG_W), .RST_CYC(RST_CYC), .CFG_DEFAULT(CFG_DEFAULT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .rd_en(cfg_rd_en), .cfg_q(cfg_q), .busy(soft_rst_req)
  );

  // Output stage toward the decoder: one slot, newest byte wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
    end else if (byte_stb) begin
      if (end_hit) begin
        cmd_valid <= 1'b0;
      end else begin
        cmd_valid <= 1'b1;
        cmd_data  <= byte_q;
      end
    end else if (cmd_valid && cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/scf_checker.sv
module scf_checker
  import scf_pkg::*;
#(
  parameter int CFG_W   = 32,
  parameter int RST_CYC = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              byte_stb,
  input logic [BYTE_W-1:0] cmd_data,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              resync_pulse,
  input logic              cfg_wr_en,
  input logic              cfg_rd_en,
  input logic [CFG_W-1:0]  cfg_q,
  input logic              soft_rst_req
);
  localparam int HW = $clog2(RST_CYC + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else if (soft_rst_req) hi_cnt <= (hi_cnt == HW'(RST_CYC + 1)) ? hi_cnt : hi_cnt + 1'b1;
    else hi_cnt <= '0;
  end

  p_rst_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |-> hi_cnt < HW'(RST_CYC));

  p_rst_len_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_rst_req) |-> (hi_cnt == HW'(RST_CYC)) && cfg_q[DONE_BIT]);

  p_rst_bit_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[RST_BIT]);

  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_en && !soft_rst_req) |=> !cfg_q[DONE_BIT]);

  p_hold_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !byte_stb) |=> cmd_valid && $stable(cmd_data));

  p_no_bits_deselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !byte_stb);

  p_pulse_after_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resync_pulse |-> $past(byte_stb) && !cmd_valid);

  p_cfg_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr_en && !cfg_rd_en && !soft_rst_req) |=> $stable(cfg_q));
endmodule

bind serial_cmd_front scf_checker #(.CFG_W(CFG_W), .RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_stb(byte_stb),
  .cmd_data(cmd_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .resync_pulse(resync_pulse), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
  .cfg_q(cfg_q), .soft_rst_req(soft_rst_req)
);

// File: tb/tb_serial_cmd_front.sv
module tb_serial_cmd_front;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        sclk = 0, sdin = 0, cs_n = 1;
  logic [7:0]  cmd_data;
  logic        cmd_valid, cmd_ready = 1;
  logic        resync_pulse;
  logic        cfg_wr_en = 0, cfg_rd_en = 0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_q;
  logic        soft_rst_req;

  int n_chk = 0, n_fail = 0, n_sync = 0;
  logic [7:0] exp_q[$];

  serial_cmd_front dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .cs_n(cs_n),
    .cmd_data(cmd_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .resync_pulse(resync_pulse), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_en(cfg_rd_en), .cfg_q(cfg_q), .soft_rst_req(soft_rst_req)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: away from both edges, pop on each handshake, count pulses
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n && cmd_valid && cmd_ready) begin
      if (exp_q.size() == 0) chk(0, "R1 unexpected byte", {24'h0, cmd_data}, 32'h0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(cmd_data == e, "R1 scoreboard byte", {24'h0, cmd_data}, {24'h0, e});
      end
    end
    if (rst_n && resync_pulse) n_sync++;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk); sdin = b[i]; sclk = 1;
      @(negedge clk); sclk = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit expect_out);
    send_bits(b, 8);
    if (expect_out) exp_q.push_back(b);
  endtask

  task automatic cfg_write(input logic [31:0] v);
    @(negedge clk); cfg_wr_en = 1; cfg_wr_data = v;
    @(negedge clk); cfg_wr_en = 0;
  endtask

  task automatic cfg_read();
    @(negedge clk); cfg_rd_en = 1;
    @(negedge clk); cfg_rd_en = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    int s0, n;
    idle(3); rst_n = 1; idle(2);
    // R12 reset state
    chk(cfg_q == 32'h0, "R12 cfg default", cfg_q, 32'h0);
    chk(!cmd_valid && !soft_rst_req && !resync_pulse, "R12 outputs idle",
        {cmd_valid, soft_rst_req, resync_pulse}, 0);

    // R1 basic bytes
    cs_n = 0;
    send_byte(8'hA5, 1); send_byte(8'h3C, 1); send_byte(8'h00, 1);
    idle(3);
    chk(exp_q.size() == 0, "R1 all bytes delivered", exp_q.size(), 0);

    // R3 partial byte dropped on deselect
    send_bits(8'hF0, 4); cs_n = 1; idle(2); cs_n = 0;
    send_byte(8'h5A, 1); idle(3);
    chk(exp_q.size() == 0 && !cmd_valid, "R3 only full byte after reselect", exp_q.size(), 0);
    cs_n = 1; send_bits(8'hFF, 8); idle(3);
    chk(!cmd_valid, "R3 no bytes while deselected", cmd_valid, 0);
    cs_n = 0;

    // R2 back-pressure and overwrite
    cmd_ready = 0;
    send_byte(8'h11, 0); idle(2);
    chk(cmd_valid && cmd_data == 8'h11, "R2 pending byte", cmd_data, 8'h11);
    idle(5);
    chk(cmd_valid && cmd_data == 8'h11, "R2 pending held", cmd_data, 8'h11);
    send_byte(8'h22, 1); idle(2);
    chk(cmd_valid && cmd_data == 8'h22, "R2 overwrite by newer byte", cmd_data, 8'h22);
    cmd_ready = 1; idle(3);
    chk(!cmd_valid && exp_q.size() == 0, "R2 drop after accept", cmd_valid, 0);

    // R11 plain write
    cfg_write(32'h1000_1234);
    chk(cfg_q == 32'h0000_1234, "R11 write loads fields, flag not writable", cfg_q, 32'h0000_1234);

    // R4 resync with exactly 15, pending withdrawn, R7 cfg untouched
    s0 = n_sync;
    cmd_ready = 0;
    for (int i = 0; i < 15; i++) send_byte(8'hFF, 0);
    send_byte(8'hFE, 0); idle(3);
    chk(n_sync == s0 + 1, "R4 pulse after 15xFF+FE", n_sync - s0, 1);
    chk(!cmd_valid, "R4 terminator not presented, pending withdrawn", cmd_valid, 0);
    chk(cfg_q == 32'h0000_1234, "R7 cfg unchanged by resync", cfg_q, 32'h0000_1234);
    cmd_ready = 1;

    // R5 saturation: 20 FF then FE
    s0 = n_sync;
    for (int i = 0; i < 20; i++) send_byte(8'hFF, 1);
    send_byte(8'hFE, 0); idle(3);
    chk(n_sync == s0 + 1, "R5 longer run still qualifies", n_sync - s0, 1);
    // R5 too short
    s0 = n_sync;
    for (int i = 0; i < 14; i++) send_byte(8'hFF, 1);
    send_byte(8'hFE, 1); idle(3);
    chk(n_sync == s0, "R5 14xFF+FE is ordinary", n_sync - s0, 0);
    // R5 interrupted run
    s0 = n_sync;
    for (int i = 0; i < 15; i++) send_byte(8'hFF, 1);
    send_byte(8'h00, 1); send_byte(8'hFE, 1); idle(3);
    chk(n_sync == s0, "R5 other byte clears run", n_sync - s0, 0);

    // R6 run survives select toggles
    s0 = n_sync;
    for (int i = 0; i < 15; i++) begin
      send_byte(8'hFF, 1); cs_n = 1; idle(2); cs_n = 0;
    end
    send_byte(8'hFE, 0); idle(3);
    chk(n_sync == s0 + 1, "R6 count kept across deselect", n_sync - s0, 1);
    chk(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);

    // R8 software reset; other fields of the write ignored
    cfg_write(32'h2000_ABCD);
    chk(soft_rst_req && cfg_q == 32'h0, "R8 reset loads default", cfg_q, 32'h0);
    n = 0;
    repeat (12) begin
      if (soft_rst_req) n++;
      @(negedge clk);
    end
    chk(n == 8, "R8 request length", n, 8);
    chk(cfg_q == 32'h1000_0000, "R9 done flag set", cfg_q, 32'h1000_0000);

    // R11 write keeps flag, R10 read clears it
    cfg_write(32'h0000_5678);
    chk(cfg_q == 32'h1000_5678, "R11 flag kept on write", cfg_q, 32'h1000_5678);
    cfg_read();
    chk(cfg_q == 32'h0000_5678, "R10 read clears flag", cfg_q, 32'h0000_5678);

    // R11 write during reset ignored
    cfg_write(32'h2000_0000);
    cfg_write(32'h0000_00FF);
    idle(10);
    chk(cfg_q == 32'h1000_0000, "R11 write during reset ignored", cfg_q, 32'h1000_0000);
    chk(!soft_rst_req, "R8 request ended", soft_rst_req, 0);

    finish_run();
  end
endmodule